// File: doc/BRIEF.md
# Instruction TLB Diagnostic Access Port

This block holds a 16-entry instruction translation buffer together with a one-entry first-level buffer in front of it. It offers a register-style port through which a debug agent can inspect and modify both. The agent first loads an entry pointer. It then moves whole entries through one of two data addresses: a plain one, and a stepping one that advances the pointer after every access.

A separate address exposes the replacement-history bits, which are readable and writable. The first-level buffer is readable at its own address and needs no pointer. Normal lookups search the array, report a hit and its frame number, refresh the replacement history, and load the first-level buffer. A mode-change strobe invalidates everything. The buffer is always active, and no enable control exists.

Register map: address 0 is the pointer, 1 is the plain entry port, 2 is the stepping entry port, 3 is the replacement history, and 4 is the first-level buffer. An entry word carries the valid flag in bit 31, the virtual page number in bits [27:16] and the frame number in bits [11:0]. All other bits read as zero.

Top module: `itlb_diag_port`

## Requirements
- R1: After reset, the pointer reads 0, every entry reads 0 (invalid, with zero page and frame), the history reads 0 and the first-level word reads 0.
- R2: A write to address 0 keeps only bits [3:0] as the pointer. A read of address 0 returns the pointer with bits [31:4] zero.
- R3: A read or write at address 1 accesses the entry the pointer selects, using the entry word layout, and leaves the pointer unchanged.
- R4: A read or write at address 2 accesses the selected entry. After that access the pointer advances by one, wrapping from 15 to 0.
- R5: A read request is answered by `reg_rvalid` high for exactly the next cycle, with the data in `reg_rdata`. A write never raises `reg_rvalid`.
- R6: Diagnostic accesses to entries, the pointer or the first-level word never change the replacement history.
- R7: Address 3 reads and writes the replacement history, one bit per entry, in bits [15:0].
- R8: While `lk_req` is high, `lk_hit` and `lk_pfn` report in the same cycle whether a valid entry holds `lk_vpn`, and its frame number. On a hit, the clock edge sets the hit entry's history bit. If that would set all 16 bits, only the hit entry's bit is left set.
- R9: The first-level word at address 4 reads bit 31 as valid, bits [19:16] as the index of the last hit entry and bits [11:0] as its frame number. Writes to address 4 are ignored.
- R10: `mode_flush` clears every entry's valid flag and the first-level valid flag at the next edge. This takes priority over an entry write in the same cycle, although that write still stores its page and frame fields.
- R11: When a history write and a lookup hit fall in the same cycle, the written value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data strobe, one cycle after the request |
| reg_rdata | output | 32 | Read data |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 12 | Virtual page number to translate |
| lk_hit | output | 1 | Lookup found a valid match |
| lk_pfn | output | 12 | Frame number of the match |
| mode_flush | input | 1 | Mode-change invalidate strobe |

## Verification
The hardest cases to reach from the ports are same-cycle collisions: a flush landing on the edge of an entry write, and a history write meeting a lookup hit. The bench drives both sides of each collision in the same cycle from one task step and then reads the outcome back through the register port. The saturation rule of the history needs all 16 entries hit in order. The bench reaches it by filling the whole array through the stepping port and then sweeping lookups over every page number.

// File: rtl/itlb_diag_port.sv
module itlb_diag_port #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 12,
  parameter int PFN_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_req,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic             reg_rvalid,
  output logic [31:0]      reg_rdata,
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             mode_flush
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [2:0] A_IDX = 3'd0, A_ENT = 3'd1, A_ENTI = 3'd2, A_LRU = 3'd3, A_L0 = 3'd4;

  logic [IDX_W-1:0]   idx;
  logic [ENTRIES-1:0] vld, mru;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic               l0_vld;
  logic [IDX_W-1:0]   l0_idx;
  logic [PFN_W-1:0]   l0_pfn;

  logic               match;
  logic [IDX_W-1:0]   hit_idx;
  logic [31:0]        rd_mux;

  wire wr_go   = reg_req && reg_wr;
  wire ent_wr  = wr_go && (reg_addr == A_ENT || reg_addr == A_ENTI);
  wire lru_wr  = wr_go && reg_addr == A_LRU;
  wire hit_go  = lk_req && match;

  assign lk_hit = hit_go;
  assign lk_pfn = pfn_q[hit_idx];

  always_comb begin
    match   = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (vld[i] && vpn_q[i] == lk_vpn) begin
        match   = 1'b1;
        hit_idx = IDX_W'(i);
      end
  end

  wire [ENTRIES-1:0] hit_oh  = {{(ENTRIES-1){1'b0}}, 1'b1} << hit_idx;
  wire [ENTRIES-1:0] mru_or  = mru | hit_oh;
  wire [ENTRIES-1:0] mru_nxt = (&mru_or) ? hit_oh : mru_or;

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_IDX: rd_mux[IDX_W-1:0] = idx;
      A_ENT, A_ENTI: begin
        rd_mux[31]          = vld[idx];
        rd_mux[16+:VPN_W]   = vpn_q[idx];
        rd_mux[PFN_W-1:0]   = pfn_q[idx];
      end
      A_LRU: rd_mux[ENTRIES-1:0] = mru;
      A_L0: begin
        rd_mux[31]          = l0_vld;
        rd_mux[16+:IDX_W]   = l0_idx;
        rd_mux[PFN_W-1:0]   = l0_pfn;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx        <= '0;
      vld        <= '0;
      mru        <= '0;
      l0_vld     <= 1'b0;
      l0_idx     <= '0;
      l0_pfn     <= '0;
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i] <= '0;
        pfn_q[i] <= '0;
      end
    end else begin
      reg_rvalid <= reg_req && !reg_wr;
      if (reg_req && !reg_wr) reg_rdata <= rd_mux;

      if (wr_go && reg_addr == A_IDX) idx <= reg_wdata[IDX_W-1:0];
      else if (reg_req && reg_addr == A_ENTI) idx <= idx + 1'b1;

      if (ent_wr) begin
        vpn_q[idx] <= reg_wdata[16+:VPN_W];
        pfn_q[idx] <= reg_wdata[PFN_W-1:0];
      end
      if (mode_flush) vld <= '0;
      else if (ent_wr) vld[idx] <= reg_wdata[31];

      if (lru_wr) mru <= reg_wdata[ENTRIES-1:0];
      else if (hit_go) mru <= mru_nxt;

      if (mode_flush) l0_vld <= 1'b0;
      else if (hit_go) begin
        l0_vld <= 1'b1;
        l0_idx <= hit_idx;
        l0_pfn <= lk_pfn;
      end
    end
  end
endmodule

// File: rtl/itlb_diag_port_chk.sv
module itlb_diag_port_chk #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_req,
  input logic               reg_wr,
  input logic [2:0]         reg_addr,
  input logic               reg_rvalid,
  input logic               lk_req,
  input logic               lk_hit,
  input logic               mode_flush,
  input logic [IDX_W-1:0]   idx,
  input logic [ENTRIES-1:0] vld,
  input logic [ENTRIES-1:0] mru
);
  // R5
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_wr) |=> reg_rvalid);
  // R5
  no_spur_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rvalid |-> $past(reg_req && !reg_wr));
  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flush |=> (vld == '0));
  // R6
  lru_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_req && reg_wr && reg_addr == 3'd3) && !(lk_req && lk_hit)) |=> $stable(mru));
  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_addr == 3'd2) |=> (idx == IDX_W'($past(idx) + 1'b1)));
  // R3
  idx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_addr == 3'd1) |=> $stable(idx));
endmodule

bind itlb_diag_port itlb_diag_port_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rvalid(reg_rvalid), .lk_req(lk_req), .lk_hit(lk_hit), .mode_flush(mode_flush),
  .idx(idx), .vld(vld), .mru(mru)
);

// File: tb/sim_itlb_diag_port.sv
module sim_itlb_diag_port;
  logic clk = 0, rst_n = 0;
  logic reg_req = 0, reg_wr = 0, lk_req = 0, mode_flush = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic reg_rvalid, lk_hit;
  logic [11:0] lk_vpn = 0, lk_pfn;

  int checks = 0, fails = 0;
  logic [11:0] m_vpn [16];
  logic [11:0] m_pfn [16];
  logic [15:0] m_v, m_mru;
  logic [3:0]  m_idx;
  logic [31:0] m_l0, rd;

  always #10 clk = ~clk;

  itlb_diag_port u0 (.clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .mode_flush(mode_flush));

  function automatic logic [31:0] mk(logic v, logic [11:0] vp, logic [11:0] pf);
    return {v, 3'b0, vp, 4'b0, pf};
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_req = 1; reg_wr = 0; reg_addr = a;
    @(negedge clk); reg_req = 0;
    chk("R5", {31'b0, reg_rvalid}, 1);
    d = reg_rdata;
    @(negedge clk);
    chk("R5", {31'b0, reg_rvalid}, 0);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_req = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_req = 0; reg_wr = 0;
    if (reg_rvalid) chk("R5", 1, 0);
  endtask

  task automatic model_hit(int i);
    logic [15:0] o;
    o = m_mru | (16'h1 << i);
    m_mru = (&o) ? (16'h1 << i) : o;
    m_l0 = {1'b1, 11'b0, 4'(i), 4'b0, m_pfn[i]};
  endtask

  task automatic lookup(input logic [11:0] v, input int exp_i);
    @(negedge clk); lk_req = 1; lk_vpn = v;
    #1;
    chk("R8", {31'b0, lk_hit}, {31'b0, exp_i >= 0});
    if (exp_i >= 0) begin
      chk("R8", {20'b0, lk_pfn}, {20'b0, m_pfn[exp_i]});
      model_hit(exp_i);
    end
    @(negedge clk); lk_req = 0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_v = 0; m_mru = 0; m_idx = 0; m_l0 = 0;
    for (int i = 0; i < 16; i++) begin m_vpn[i] = 0; m_pfn[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rreg(0, rd); chk("R1", rd, 0);
    rreg(3, rd); chk("R1", rd, 0);
    rreg(4, rd); chk("R1", rd, 0);
    for (int i = 0; i < 16; i++) begin rreg(2, rd); chk("R1", rd, 0); end
    rreg(0, rd); chk("R4", rd, 0);

    // R2 pointer width
    wreg(0, 32'hFFFF_FFF7); rreg(0, rd); chk("R2", rd, 32'h7);
    wreg(0, 0);

    // R4 fill via stepping port
    for (int i = 0; i < 16; i++) begin
      m_vpn[i] = 12'h100 + 12'(i * 3); m_pfn[i] = 12'hA00 ^ 12'(i * 17); m_v[i] = 1;
      wreg(2, mk(1, m_vpn[i], m_pfn[i]) | 32'h7000_F000);
    end
    rreg(0, rd); chk("R4", rd, 0);
    wreg(0, 14);
    rreg(2, rd); chk("R4", rd, mk(1, m_vpn[14], m_pfn[14]));
    rreg(2, rd); chk("R4", rd, mk(1, m_vpn[15], m_pfn[15]));
    rreg(0, rd); chk("R4", rd, 0);

    // R3 plain port keeps pointer
    for (int i = 0; i < 16; i++) begin
      wreg(0, i);
      rreg(1, rd); chk("R3", rd, mk(1, m_vpn[i], m_pfn[i]));
      rreg(0, rd); chk("R3", rd, i);
    end
    wreg(0, 5);
    m_pfn[5] = 12'h5A5;
    wreg(1, mk(1, m_vpn[5], m_pfn[5]));
    rreg(1, rd); chk("R3", rd, mk(1, m_vpn[5], m_pfn[5]));
    rreg(0, rd); chk("R3", rd, 5);

    // R6 history untouched by diagnostics
    rreg(3, rd); chk("R6", rd, 0);
    rreg(4, rd); chk("R6", rd, 0);

    // R8 lookups, saturation on the last one
    for (int i = 0; i < 16; i++) begin
      lookup(m_vpn[i], i);
      rreg(3, rd); chk("R8", rd, {16'b0, m_mru});
      rreg(4, rd); chk("R9", rd, m_l0);
    end
    chk("R8", {16'b0, m_mru}, 32'h8000);
    lookup(12'hFFF, -1);
    rreg(3, rd); chk("R8", rd, {16'b0, m_mru});

    // R9 first-level word ignores writes
    wreg(4, 32'hDEAD_BEEF);
    rreg(4, rd); chk("R9", rd, m_l0);
    rreg(3, rd); chk("R6", rd, {16'b0, m_mru});

    // R7 history read/write
    wreg(3, 32'hFFFF_1234); m_mru = 16'h1234;
    rreg(3, rd); chk("R7", rd, 32'h1234);

    // R11 history write vs hit in the same cycle
    @(negedge clk); reg_req = 1; reg_wr = 1; reg_addr = 3; reg_wdata = 32'hAA;
    lk_req = 1; lk_vpn = m_vpn[2];
    @(negedge clk); reg_req = 0; reg_wr = 0; lk_req = 0;
    model_hit(2); m_mru = 16'hAA;
    rreg(3, rd); chk("R11", rd, 32'hAA);
    rreg(4, rd); chk("R9", rd, m_l0);

    // R10 flush beats a same-cycle entry write
    wreg(0, 3);
    @(negedge clk); reg_req = 1; reg_wr = 1; reg_addr = 1;
    reg_wdata = mk(1, 12'h777, 12'h888); mode_flush = 1;
    @(negedge clk); reg_req = 0; reg_wr = 0; mode_flush = 0;
    m_vpn[3] = 12'h777; m_pfn[3] = 12'h888; m_v = 0; m_l0[31] = 0;
    wreg(0, 0);
    for (int i = 0; i < 16; i++) begin rreg(2, rd); chk("R10", rd, mk(0, m_vpn[i], m_pfn[i])); end
    rreg(4, rd); chk("R10", rd, m_l0);
    lookup(m_vpn[7], -1);
    rreg(3, rd); chk("R10", rd, 32'hAA);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule